// File: doc/BRIEF.md
# Parallel Port Extended Control and Interrupt Register

This block is the host-visible extended control register of an enhanced parallel port. It holds a three-bit operating mode, an active-low error-interrupt enable, a DMA enable and a self-setting service-interrupt bit. It combines those settings with the FAULT line, the DMA terminal-count strobe and the FIFO status to raise one level-sensitive host interrupt. It also decides when the interrupt pin and the DMA request pin may drive the bus.

The host writes the register with a single-cycle write strobe and sees its contents on a combinational read bus. Interrupt causes are held until the host takes the clear action that belongs to each cause. The service bit works as an active-low arm: writing 0 arms it, the hardware flips it to 1 when it fires, and writing 1 disarms it.

Top module: `pp_ext_ctrl_reg`

## Requirements
- R1: After synchronous reset the mode is 000, the error-interrupt disable bit is 1, DMA enable is 0 and the service bit is 1. `irq` is 0 and both output enables are 0, so with an empty FIFO the read bus shows 0x15.
- R2: The read bus is laid out as follows. Bits [7:5] hold the mode and bit 4 holds the error-interrupt disable. Bit 3 is DMA enable and bit 2 is the live service bit. Bit 1 is FIFO full and bit 0 is FIFO empty.
- R3: When bit 4 is 0, a high-to-low transition on `fault_n_in` raises `irq` on the third rising clock edge after the change. When bit 4 is 1, the transition is ignored. A host write with bit 4 = 1 clears this interrupt.
- R4: A write that takes bit 4 from 1 to 0 while `fault_n_in` is held low raises `irq` on the edge of that write.
- R5: Writing bit 2 = 0 arms the service interrupt. When a service condition is seen while armed, the hardware sets bit 2 to 1 and raises `irq`. While bit 2 is 1, no service condition raises an interrupt.
- R6: `tc_in` is a service condition only while DMA enable is 1. The interrupt it causes is cleared only by a write with bit 3 = 0 or a write of mode 000 or 001; any other write leaves it pending.
- R7: With DMA enable 0, a FIFO threshold is a service condition. In the forward direction (`dir_rev` = 0) it comes from `fifo_wr_thr`, and in the reverse direction (`dir_rev` = 1) it comes from `fifo_rd_thr`. The threshold ignored for the current direction has no effect, and a threshold with DMA enable 1 has no effect. Any host write clears this interrupt.
- R8: A `fifo_err` pulse is a service condition in either transfer mode. Whether or not the service bit is armed, it forces read bits [1:0] to 11. Both that status and the interrupt hold until a write of mode 000 or 001, and survive other writes.
- R9: `dreq_oe` equals DMA enable.
- R10: `irq_oe` is 1 when `ack_irq_en` is 1, or when the mode is 010, 011 or 110. It is 0 otherwise.
- R11: `irq` is the OR of the pending causes and of `ack_irq_en & ack_int`. The FAULT and acknowledge paths do not depend on the service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register read-back |
| fault_n_in | input | 1 | FAULT line, asynchronous, low = asserted |
| tc_in | input | 1 | DMA terminal count strobe |
| dir_rev | input | 1 | Transfer direction, 1 = reverse |
| fifo_wr_thr | input | 1 | Forward threshold: room for a threshold of bytes |
| fifo_rd_thr | input | 1 | Reverse threshold: a threshold of bytes to read |
| fifo_err | input | 1 | FIFO overrun or underrun pulse |
| fifo_full | input | 1 | FIFO full status |
| fifo_empty | input | 1 | FIFO empty status |
| ack_irq_en | input | 1 | Acknowledge-interrupt enable from the port control register |
| ack_int | input | 1 | Acknowledge interrupt request |
| irq | output | 1 | Host interrupt request, active-high level |
| irq_oe | output | 1 | Output enable of the interrupt pin |
| dreq_oe | output | 1 | Output enable of the DMA request pin |

## Verification
The bench targets the clear rules, because a design that clears too broadly or too narrowly looks correct until the second write. It checks that a plain write leaves a terminal-count interrupt pending, that the FIFO error status survives a write that keeps the mode at 011, and that the mode-000 write drops both. It checks that the threshold chosen by the other direction, and any threshold while DMA is on, are ignored; a design with the threshold inputs swapped would fire in the reverse test. It checks the three-edge FAULT latency, sampling one edge early to expose a missing synchroniser stage. It also checks the interrupt raised by clearing bit 4 while FAULT is already low, which an edge-only detector would miss.

// File: rtl/ecr_pkg.sv
package ecr_pkg;

    localparam int MODE_W = 3;
    localparam int STAT_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_COMPAT   = 3'b000,
        MODE_BYTE     = 3'b001,
        MODE_FIFO_OUT = 3'b010,
        MODE_EXTENDED = 3'b011,
        MODE_RSV4     = 3'b100,
        MODE_RSV5     = 3'b101,
        MODE_TEST     = 3'b110,
        MODE_CFG      = 3'b111
    } pp_mode_e;

    // control fields, most significant first as they sit on the bus
    typedef struct packed {
        pp_mode_e mode;
        logic     err_int_dis;
        logic     dma_en;
        logic     svc;
    } ctrl_fields_t;

    localparam int CTRL_W = $bits(ctrl_fields_t);
    localparam int REG_W  = CTRL_W + STAT_W;

    // pending service causes
    typedef struct packed {
        logic tc;
        logic thr;
        logic err;
    } svc_pend_t;

    function automatic logic mode_clears_irq(pp_mode_e m);
        return (m == MODE_COMPAT) || (m == MODE_BYTE);
    endfunction

    function automatic logic mode_drives_irq(pp_mode_e m);
        return (m == MODE_FIFO_OUT) || (m == MODE_EXTENDED) || (m == MODE_TEST);
    endfunction

endpackage

// File: rtl/ecr_fault_unit.sv
module ecr_fault_unit #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic fault_n_in,
    input  logic err_int_dis,
    input  logic wr_en,
    input  logic wr_err_int_dis,
    output logic fault_pend
);

    logic fault_n_sync;
    logic fault_n_prev;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            logic [SYNC_STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[SYNC_STAGES-2:0], fault_n_in};
            end
            assign fault_n_sync = chain[SYNC_STAGES-1];
        end else begin : g_single
            logic stage;
            always_ff @(posedge clk) begin
                if (rst) stage <= 1'b1;
                else     stage <= fault_n_in;
            end
            assign fault_n_sync = stage;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) fault_n_prev <= 1'b1;
        else     fault_n_prev <= fault_n_sync;
    end

    logic fall_edge;
    logic enable_while_low;
    logic set_pend;
    logic clr_pend;

    always_comb begin
        fall_edge        = fault_n_prev & ~fault_n_sync;
        enable_while_low = wr_en & err_int_dis & ~wr_err_int_dis & ~fault_n_sync;
        set_pend         = (~err_int_dis & fall_edge) | enable_while_low;
        clr_pend         = wr_en & wr_err_int_dis;
    end

    always_ff @(posedge clk) begin
        if (rst)           fault_pend <= 1'b0;
        else if (set_pend) fault_pend <= 1'b1;
        else if (clr_pend) fault_pend <= 1'b0;
    end

endmodule

// File: rtl/ecr_service_unit.sv
module ecr_service_unit
    import ecr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  logic      wr_svc,
    input  logic      wr_dma_en,
    input  logic      wr_mode_clear,
    input  logic      dma_en,
    input  logic      tc_in,
    input  logic      dir_rev,
    input  logic      fifo_wr_thr,
    input  logic      fifo_rd_thr,
    input  logic      fifo_err,
    output logic      svc,
    output svc_pend_t pend,
    output logic      err_sticky
);

    svc_pend_t cond;
    logic      armed;
    logic      fire;

    always_comb begin
        cond.tc  = dma_en & tc_in;
        cond.thr = ~dma_en & (dir_rev ? fifo_rd_thr : fifo_wr_thr);
        cond.err = fifo_err;
        armed    = ~svc;
        fire     = armed & (|cond);
    end

    // hardware set has priority over a write in the same cycle
    always_ff @(posedge clk) begin
        if (rst)        svc <= 1'b1;
        else if (fire)  svc <= 1'b1;
        else if (wr_en) svc <= wr_svc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            if (armed & cond.tc)
                pend.tc <= 1'b1;
            else if (wr_en & (~wr_dma_en | wr_mode_clear))
                pend.tc <= 1'b0;

            if (armed & cond.thr)
                pend.thr <= 1'b1;
            else if (wr_en)
                pend.thr <= 1'b0;

            if (armed & cond.err)
                pend.err <= 1'b1;
            else if (wr_en & wr_mode_clear)
                pend.err <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                         err_sticky <= 1'b0;
        else if (fifo_err)               err_sticky <= 1'b1;
        else if (wr_en & wr_mode_clear)  err_sticky <= 1'b0;
    end

endmodule

// File: rtl/ecr_pin_enables.sv
module ecr_pin_enables
    import ecr_pkg::*;
(
    input  pp_mode_e  mode,
    input  logic      dma_en,
    input  logic      ack_irq_en,
    input  logic      ack_int,
    input  logic      fault_pend,
    input  svc_pend_t svc_pend,
    output logic      irq,
    output logic      irq_oe,
    output logic      dreq_oe
);

    always_comb begin
        irq     = fault_pend | (|svc_pend) | (ack_irq_en & ack_int);
        irq_oe  = ack_irq_en | mode_drives_irq(mode);
        dreq_oe = dma_en;
    end

endmodule

// File: rtl/pp_ext_ctrl_reg.sv
module pp_ext_ctrl_reg
    import ecr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_we,
    input  logic [REG_W-1:0] host_wdata,
    output logic [REG_W-1:0] host_rdata,
    input  logic             fault_n_in,
    input  logic             tc_in,
    input  logic             dir_rev,
    input  logic             fifo_wr_thr,
    input  logic             fifo_rd_thr,
    input  logic             fifo_err,
    input  logic             fifo_full,
    input  logic             fifo_empty,
    input  logic             ack_irq_en,
    input  logic             ack_int,
    output logic             irq,
    output logic             irq_oe,
    output logic             dreq_oe
);

    ctrl_fields_t wr_fields;
    ctrl_fields_t rd_fields;
    pp_mode_e     mode_q;
    logic         err_dis_q;
    logic         dma_en_q;
    logic         svc_q;
    svc_pend_t    svc_pend;
    logic         err_sticky;
    logic         fault_pend;
    logic         wr_mode_clear;

    assign wr_fields     = ctrl_fields_t'(host_wdata[REG_W-1:STAT_W]);
    assign wr_mode_clear = mode_clears_irq(wr_fields.mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= MODE_COMPAT;
            err_dis_q <= 1'b1;
            dma_en_q  <= 1'b0;
        end else if (host_we) begin
            mode_q    <= wr_fields.mode;
            err_dis_q <= wr_fields.err_int_dis;
            dma_en_q  <= wr_fields.dma_en;
        end
    end

    ecr_fault_unit #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_fault (
        .clk            (clk),
        .rst            (rst),
        .fault_n_in     (fault_n_in),
        .err_int_dis    (err_dis_q),
        .wr_en          (host_we),
        .wr_err_int_dis (wr_fields.err_int_dis),
        .fault_pend     (fault_pend)
    );

    ecr_service_unit u_svc (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (host_we),
        .wr_svc        (wr_fields.svc),
        .wr_dma_en     (wr_fields.dma_en),
        .wr_mode_clear (wr_mode_clear),
        .dma_en        (dma_en_q),
        .tc_in         (tc_in),
        .dir_rev       (dir_rev),
        .fifo_wr_thr   (fifo_wr_thr),
        .fifo_rd_thr   (fifo_rd_thr),
        .fifo_err      (fifo_err),
        .svc           (svc_q),
        .pend          (svc_pend),
        .err_sticky    (err_sticky)
    );

    ecr_pin_enables u_pins (
        .mode       (mode_q),
        .dma_en     (dma_en_q),
        .ack_irq_en (ack_irq_en),
        .ack_int    (ack_int),
        .fault_pend (fault_pend),
        .svc_pend   (svc_pend),
        .irq        (irq),
        .irq_oe     (irq_oe),
        .dreq_oe    (dreq_oe)
    );

    always_comb begin
        rd_fields.mode        = mode_q;
        rd_fields.err_int_dis = err_dis_q;
        rd_fields.dma_en      = dma_en_q;
        rd_fields.svc         = svc_q;
        host_rdata = {rd_fields, fifo_full | err_sticky, fifo_empty | err_sticky};
    end

endmodule

// File: rtl/ecr_checker.sv
module ecr_checker
    import ecr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             host_we,
    input logic [REG_W-1:0] host_rdata,
    input logic             fifo_err,
    input logic             ack_irq_en,
    input logic             ack_int,
    input logic             irq,
    input logic             irq_oe,
    input logic             dreq_oe
);

    // R9
    dreq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        dreq_oe == host_rdata[3]);

    // R10
    irq_oe_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!ack_irq_en && host_rdata[7:6] == 2'b00) |-> !irq_oe);

    // R11
    ack_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_irq_en && ack_int) |-> irq);

    // R8
    err_status_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_err |=> (host_rdata[1:0] == 2'b11));

    // R5
    svc_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (!host_rdata[2] && !host_we) |=> (!host_rdata[2] || irq));

endmodule

bind pp_ext_ctrl_reg ecr_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_we    (host_we),
    .host_rdata (host_rdata),
    .fifo_err   (fifo_err),
    .ack_irq_en (ack_irq_en),
    .ack_int    (ack_int),
    .irq        (irq),
    .irq_oe     (irq_oe),
    .dreq_oe    (dreq_oe)
);

// File: tb/sim_pp_ext_ctrl_reg.sv
module sim_pp_ext_ctrl_reg;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_we = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       fault_n_in = 1'b1;
    logic       tc_in = 1'b0;
    logic       dir_rev = 1'b0;
    logic       fifo_wr_thr = 1'b0;
    logic       fifo_rd_thr = 1'b0;
    logic       fifo_err = 1'b0;
    logic       fifo_full = 1'b0;
    logic       fifo_empty = 1'b1;
    logic       ack_irq_en = 1'b0;
    logic       ack_int = 1'b0;
    logic       irq;
    logic       irq_oe;
    logic       dreq_oe;

    always #10 clk = ~clk;   // 50 MHz

    pp_ext_ctrl_reg u0 (.*);

    typedef struct packed {
        logic [7:0] rd;
        logic       irq;
        logic       irq_oe;
        logic       dreq_oe;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;

    // monitor: compares queued expectations at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (host_rdata !== e.rd || irq !== e.irq ||
                    irq_oe !== e.irq_oe || dreq_oe !== e.dreq_oe) begin
                    failures++;
                    $display("FAIL %s: rdata=%02h irq=%b irq_oe=%b dreq_oe=%b expected rdata=%02h irq=%b irq_oe=%b dreq_oe=%b",
                             t, host_rdata, irq, irq_oe, dreq_oe, e.rd, e.irq, e.irq_oe, e.dreq_oe);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] d);
        host_we    = 1'b1;
        host_wdata = d;
        tick();
        host_we    = 1'b0;
    endtask

    // driver: pushes an expectation, then waits past the comparing edge
    task automatic expect_out(input string tag, input logic [7:0] rd,
                              input logic i, input logic oe, input logic d);
        exp_t e;
        e.rd = rd; e.irq = i; e.irq_oe = oe; e.dreq_oe = d;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        expect_out("R1 reset state", 8'h15, 0, 0, 0);

        // R2 layout, R10 mode 011 drives irq, R9 dma enable
        wr(8'h68);
        expect_out("R2 R9 R10 write mode 011 dma armed", 8'h69, 0, 1, 1);

        // R6 terminal count fires
        tc_in = 1'b1; tick(); tc_in = 1'b0;
        expect_out("R6 R5 tc fires service", 8'h6D, 1, 1, 1);
        wr(8'h6C);
        expect_out("R6 plain write keeps tc pending", 8'h6D, 1, 1, 1);
        wr(8'h64);
        expect_out("R6 R9 dma disable clears tc", 8'h65, 0, 1, 0);

        // R7 forward threshold
        wr(8'h60);
        expect_out("R5 arm service", 8'h61, 0, 1, 0);
        fifo_wr_thr = 1'b1; tick(); fifo_wr_thr = 1'b0;
        expect_out("R7 forward threshold fires", 8'h65, 1, 1, 0);
        wr(8'h60);
        expect_out("R7 write clears threshold", 8'h61, 0, 1, 0);

        // R7 reverse direction
        dir_rev = 1'b1;
        fifo_wr_thr = 1'b1; tick(); fifo_wr_thr = 1'b0;
        expect_out("R7 reverse ignores write threshold", 8'h61, 0, 1, 0);
        fifo_rd_thr = 1'b1; tick(); fifo_rd_thr = 1'b0;
        expect_out("R7 reverse read threshold fires", 8'h65, 1, 1, 0);
        dir_rev = 1'b0;

        // R7 threshold ignored with dma on
        wr(8'h68);
        expect_out("R7 rearm with dma", 8'h69, 0, 1, 1);
        fifo_wr_thr = 1'b1; tick(); fifo_wr_thr = 1'b0;
        expect_out("R7 threshold ignored under dma", 8'h69, 0, 1, 1);

        // R5 disarmed ignores tc
        wr(8'h6C);
        tc_in = 1'b1; tick(); tc_in = 1'b0;
        expect_out("R5 disarmed ignores tc", 8'h6D, 0, 1, 1);

        // R8 fifo error
        wr(8'h60);
        fifo_err = 1'b1; tick(); fifo_err = 1'b0;
        expect_out("R8 fifo error fires", 8'h67, 1, 1, 0);
        wr(8'h64);
        expect_out("R8 error survives mode 011 write", 8'h67, 1, 1, 0);
        wr(8'h24);
        expect_out("R8 R10 mode 001 clears error", 8'h25, 0, 0, 0);
        fifo_err = 1'b1; tick(); fifo_err = 1'b0;
        expect_out("R8 status set while disarmed", 8'h27, 0, 0, 0);
        wr(8'h04);
        expect_out("R8 mode 000 clears status", 8'h05, 0, 0, 0);

        // R3 fault edge
        wr(8'h40);
        expect_out("R10 mode 010 drives irq", 8'h41, 0, 1, 0);
        fault_n_in = 1'b0;
        tick(); tick();
        expect_out("R3 fault not yet seen after two edges", 8'h41, 0, 1, 0);
        tick();
        expect_out("R3 R11 fault interrupt, service untouched", 8'h41, 1, 1, 0);
        wr(8'h50);
        expect_out("R3 disable write clears fault", 8'h51, 0, 1, 0);

        // R4 enable while low
        wr(8'h40);
        expect_out("R4 enabling while fault low", 8'h41, 1, 1, 0);
        wr(8'h50);
        fault_n_in = 1'b1;
        tick(); tick(); tick();
        expect_out("R3 rising fault no interrupt", 8'h51, 0, 1, 0);
        fault_n_in = 1'b0;
        tick(); tick(); tick(); tick();
        expect_out("R3 disabled fault edge ignored", 8'h51, 0, 1, 0);
        fault_n_in = 1'b1;
        tick(); tick(); tick();

        // R11 acknowledge path
        ack_irq_en = 1'b1;
        wr(8'h14);
        expect_out("R10 ack enable drives irq pin", 8'h15, 0, 1, 0);
        ack_int = 1'b1; tick();
        expect_out("R11 ack interrupt", 8'h15, 1, 1, 0);
        ack_int = 1'b0; ack_irq_en = 1'b0; tick();
        expect_out("R10 R11 ack disabled", 8'h15, 0, 0, 0);

        // R10 remaining modes
        wr(8'hD4);
        expect_out("R10 mode 110 drives irq pin", 8'hD5, 0, 1, 0);
        wr(8'hF4);
        expect_out("R10 mode 111 tri-states irq pin", 8'hF5, 0, 0, 0);
        wr(8'h94);
        expect_out("R10 mode 100 tri-states irq pin", 8'h95, 0, 0, 0);

        // R2 full status
        fifo_full = 1'b1; fifo_empty = 1'b0; tick();
        expect_out("R2 full status bits", 8'h96, 0, 0, 0);
        fifo_full = 1'b0; fifo_empty = 1'b1;

        // R6 mode 000 clears tc with dma still on
        wr(8'h68);
        tc_in = 1'b1; tick(); tc_in = 1'b0;
        expect_out("R6 tc fires again", 8'h6D, 1, 1, 1);
        wr(8'h0C);
        expect_out("R6 R9 mode 000 clears tc", 8'h0D, 0, 0, 1);

        @(negedge clk);
        #1;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule